// File: doc/BRIEF.md
# Multi-Mode PWM and Sigma-Delta Output Unit

This block is a pulse-width modulation peripheral that a host programs through byte writes. One control byte picks the operating mode, the clock source for the counter and a prescale ratio. Four data bytes form two 16-bit channel values. The block drives two output pins. Depending on the mode, the pins carry a single PWM wave with a variable period, twin PWM waves on a shared or separate period, or first-order sigma-delta bitstreams that become analog levels after an external low-pass filter.

A channel value is written low byte first. The low byte waits in a hidden holding register. Writing the high byte moves the whole 16-bit value into a pending slot. The pending value reaches the working register only when the channel's current cycle ends, so a cycle that has started always finishes with consistent data. While the unit is disabled, a pending value is taken over on the next clock.

The top is a state machine. Its states are OFF, VAR (variable period), TWIN16, TWIN8, DUAL8, SD_NRZ, RZ_SPACE and RZ_MARK. A control write moves the machine to the state that belongs to the new mode: 000 and 111 go to OFF, 001 to VAR, 010 to TWIN8, 011 to TWIN16, 100 to SD_NRZ, 101 to DUAL8 and 110 to RZ_SPACE. On each prescaled tick, RZ_SPACE moves to RZ_MARK and RZ_MARK moves back to RZ_SPACE. All other states stay as they are until the next control write.

Top module: `pwm_unit`

## Requirements
- R1: After reset the control byte is 0x00, the unit is disabled and both outputs are low.
- R2: Control bits [6:4] select the mode: 000 disabled, 001 variable-period PWM, 010 twin 8-bit PWM, 011 twin 16-bit PWM, 100 NRZ sigma-delta, 101 dual 8-bit PWM, 110 RZ sigma-delta. Code 111 behaves as disabled. In a disabled mode both outputs are low.
- R3: Control bits [1:0] select the counter source. 11 is every system clock. 10 is each rising edge of `ext_clk`, after a two-flop synchroniser. 01 is each `div_tick` strobe. 00 is every fifteenth `div_tick` strobe.
- R4: Control bits [3:2] divide the selected source before it advances the counter: 00 by 1, 01 by 4, 10 by 16, 11 by 64.
- R5: Any write to the control byte, at address 0, clears the counter, the prescaler, the divide-by-15 stage and the sigma-delta accumulators. This holds even when the value written is unchanged.
- R6: Channel 0 uses address 1 for its low byte and address 2 for its high byte. Channel 1 uses addresses 3 and 4. Writing a low byte alone changes no output. A high-byte write moves {high, held low} into a pending value.
- R7: A pending value becomes active only at the tick that ends the channel's current cycle. When the unit is disabled, it becomes active on the next clock.
- R8: Mode 001: a counter runs from 0 up to channel 0's value inclusive and then wraps. Output 1 is high while the counter is below channel 1's value. Output 0 stays low.
- R9: Mode 011: a 16-bit counter wraps after 0xFFFF. Each output is high while the counter is below its own channel's value.
- R10: Mode 010: each channel has its own 8-bit counter. The counter runs from 0 up to the channel's high byte inclusive. The output is high while that counter is below the channel's low byte.
- R11: Mode 101: both channels share one 8-bit counter with a period of 256. Each output is high while the counter is below its channel's low byte.
- R12: Mode 100: on every tick each channel adds its value into a 16-bit accumulator. The output holds the carry of the latest addition, so after n ticks it has produced floor(n*V/65536) ones.
- R13: Mode 110: additions take place on alternate ticks. The carry appears on the output for one tick interval, and the output is then low for the next interval.
- R14: When control bit 7 is set, output 0 is held low and output 1 is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1/2 channel 0 low/high, 3/4 channel 1 low/high |
| wr_data | input | 8 | Write data byte |
| div_tick | input | 1 | One-cycle strobe from the system clock divided by the configurable factor |
| ext_clk | input | 1 | Asynchronous external counter clock |
| pwm_out0 | output | 1 | First output pin |
| pwm_out1 | output | 1 | Second output pin |

## Verification
The embedded assertions check several relations on every cycle. Consecutive ticks never occur when the prescaler is above one. A control write always leaves the counter and the accumulators at zero. The variable-period counter never passes its period. Output 0 stays silent in the variable-period mode and in the disabled state, and both outputs are low in the RZ space phase. The working value never moves except at a commit. Other behaviour depends on long stretches of cycles and only the bench scenarios can show it. That includes the duty-cycle sweeps, a mid-cycle update waiting for the wrap, the low byte alone having no effect, the exact sigma-delta bit sequences and the counting rate for each source and prescale setting.

// File: rtl/pwm_unit_pkg.sv
package pwm_unit_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_VAR    = 3'd1,
        MODE_TWIN8  = 3'd2,
        MODE_TWIN16 = 3'd3,
        MODE_SD_NRZ = 3'd4,
        MODE_DUAL8  = 3'd5,
        MODE_SD_RZ  = 3'd6,
        MODE_RSVD   = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_VAR,
        ST_TWIN16,
        ST_TWIN8,
        ST_DUAL8,
        ST_SD_NRZ,
        ST_RZ_SPACE,
        ST_RZ_MARK
    } state_e;

    localparam logic [2:0] ADDR_CTRL = 3'd0;

    function automatic state_e state_for_mode(input logic [2:0] code);
        state_e s;
        unique case (mode_e'(code))
            MODE_VAR:    s = ST_VAR;
            MODE_TWIN8:  s = ST_TWIN8;
            MODE_TWIN16: s = ST_TWIN16;
            MODE_SD_NRZ: s = ST_SD_NRZ;
            MODE_DUAL8:  s = ST_DUAL8;
            MODE_SD_RZ:  s = ST_RZ_SPACE;
            default:     s = ST_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int DIV_STEPS = 15,
    parameter int PRE_LOG2  = 2,
    parameter int PRE_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [1:0]           src_sel,
    input  logic [PRE_SEL_W-1:0] pre_sel,
    input  logic                 div_tick,
    input  logic                 ext_clk,
    output logic                 tick
);
    localparam int DW    = $clog2(DIV_STEPS);
    localparam int PRE_W = PRE_LOG2 * ((1 << PRE_SEL_W) - 1);

    logic [2:0]       ext_sh;
    logic             ext_rise;
    logic [DW-1:0]    div_cnt;
    logic             div_wrap;
    logic             src_en;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[1:0], ext_clk};
    end
    assign ext_rise = ext_sh[1] & ~ext_sh[2];

    assign div_wrap = div_tick && (div_cnt == DW'(DIV_STEPS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_cnt <= '0;
        else if (restart)  div_cnt <= '0;
        else if (div_wrap) div_cnt <= '0;
        else if (div_tick) div_cnt <= div_cnt + DW'(1);
    end

    always_comb begin
        unique case (src_sel)
            2'b00: src_en = div_wrap;
            2'b01: src_en = div_tick;
            2'b10: src_en = ext_rise;
            2'b11: src_en = 1'b1;
        endcase
    end

    assign pre_limit = (PRE_W'(1) << (PRE_LOG2 * int'(pre_sel))) - PRE_W'(1);
    assign tick      = src_en && (pre_cnt == pre_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (restart) pre_cnt <= '0;
        else if (tick)    pre_cnt <= '0;
        else if (src_en)  pre_cnt <= pre_cnt + PRE_W'(1);
    end

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_sel != '0 && !restart) |=> !tick);

endmodule

// File: rtl/pwm_chan_buf.sv
module pwm_chan_buf #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic               commit_ok,
    output logic [CNT_W-1:0]   active
);
    localparam int BYTE_W = CNT_W / 2;

    logic [BYTE_W-1:0] lo_hold;
    logic [CNT_W-1:0]  pend_val;
    logic              pend_flag;
    logic              take;

    assign take = pend_flag && commit_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hold   <= '0;
            pend_val  <= '0;
            pend_flag <= 1'b0;
            active    <= '0;
        end else begin
            if (wr_lo) lo_hold <= wdata;
            if (take) active <= pend_val;
            if (wr_hi) begin
                pend_val  <= {wdata, lo_hold};
                pend_flag <= 1'b1;
            end else if (take) begin
                pend_flag <= 1'b0;
            end
        end
    end

    assert_pending_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> pend_flag);

    assert_active_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(active));

endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
    import pwm_unit_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_STEPS = 15,
    parameter int PRE_LOG2  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       div_tick,
    input  logic       ext_clk,
    output logic       pwm_out0,
    output logic       pwm_out1
);
    localparam int BYTE_W = CNT_W / 2;
    localparam int NCH    = 2;

    logic [7:0]        ctrl;
    state_e            state;
    logic              restart;
    logic              tick;
    logic [BYTE_W-1:0] cnt_lo, cnt_hi;
    logic [CNT_W-1:0]  cnt16;
    logic [CNT_W-1:0]  act    [NCH];
    logic [CNT_W-1:0]  acc    [NCH];
    logic              sd_bit [NCH];
    logic [CNT_W:0]    sum    [NCH];
    logic              ch_end [NCH];
    logic              raw0, raw1;

    assign restart = wr_en && (wr_addr == ADDR_CTRL);
    assign cnt16   = {cnt_hi, cnt_lo};

    pwm_tick_gen #(.DIV_STEPS(DIV_STEPS), .PRE_LOG2(PRE_LOG2), .PRE_SEL_W(2)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .src_sel(ctrl[1:0]), .pre_sel(ctrl[3:2]),
        .div_tick(div_tick), .ext_clk(ext_clk), .tick(tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic commit_ok;
        assign commit_ok = (state == ST_OFF) || (tick && ch_end[g] && !restart);
        assign sum[g]    = {1'b0, acc[g]} + {1'b0, act[g]};
        pwm_chan_buf #(.CNT_W(CNT_W)) u_buf (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(wr_en && wr_addr == 3'(1 + 2 * g)),
            .wr_hi(wr_en && wr_addr == 3'(2 + 2 * g)),
            .wdata(wr_data), .commit_ok(commit_ok), .active(act[g])
        );
    end

    // State register: mode selection and RZ phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            state <= ST_OFF;
        end else if (restart) begin
            ctrl  <= wr_data;
            state <= state_for_mode(wr_data[6:4]);
        end else if (tick) begin
            unique case (state)
                ST_RZ_SPACE: state <= ST_RZ_MARK;
                ST_RZ_MARK:  state <= ST_RZ_SPACE;
                default:     state <= state;
            endcase
        end
    end

    // Counters and accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || restart) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            for (int c = 0; c < NCH; c++) begin
                acc[c]    <= '0;
                sd_bit[c] <= 1'b0;
            end
        end else if (tick) begin
            unique case (state)
                ST_VAR: begin
                    if (cnt16 >= act[0]) {cnt_hi, cnt_lo} <= '0;
                    else                 {cnt_hi, cnt_lo} <= cnt16 + CNT_W'(1);
                end
                ST_TWIN16: {cnt_hi, cnt_lo} <= cnt16 + CNT_W'(1);
                ST_TWIN8: begin
                    cnt_lo <= ch_end[0] ? '0 : cnt_lo + BYTE_W'(1);
                    cnt_hi <= ch_end[1] ? '0 : cnt_hi + BYTE_W'(1);
                end
                ST_DUAL8: cnt_lo <= cnt_lo + BYTE_W'(1);
                ST_SD_NRZ, ST_RZ_SPACE: begin
                    for (int c = 0; c < NCH; c++) begin
                        acc[c]    <= sum[c][CNT_W-1:0];
                        sd_bit[c] <= sum[c][CNT_W];
                    end
                end
                ST_OFF, ST_RZ_MARK: ;
            endcase
        end
    end

    // Cycle end per channel
    always_comb begin
        ch_end[0] = 1'b0;
        ch_end[1] = 1'b0;
        unique case (state)
            ST_VAR:    begin ch_end[0] = cnt16 >= act[0]; ch_end[1] = ch_end[0]; end
            ST_TWIN16: begin ch_end[0] = &cnt16;          ch_end[1] = ch_end[0]; end
            ST_TWIN8: begin
                ch_end[0] = cnt_lo >= act[0][CNT_W-1:BYTE_W];
                ch_end[1] = cnt_hi >= act[1][CNT_W-1:BYTE_W];
            end
            ST_DUAL8:  begin ch_end[0] = &cnt_lo;         ch_end[1] = ch_end[0]; end
            ST_SD_NRZ, ST_RZ_SPACE: begin ch_end[0] = 1'b1; ch_end[1] = 1'b1; end
            ST_OFF, ST_RZ_MARK: ;
        endcase
    end

    // Output process
    always_comb begin
        raw0 = 1'b0;
        raw1 = 1'b0;
        unique case (state)
            ST_VAR:    raw1 = cnt16 < act[1];
            ST_TWIN16: begin raw0 = cnt16 < act[0]; raw1 = cnt16 < act[1]; end
            ST_TWIN8: begin
                raw0 = cnt_lo < act[0][BYTE_W-1:0];
                raw1 = cnt_hi < act[1][BYTE_W-1:0];
            end
            ST_DUAL8: begin
                raw0 = cnt_lo < act[0][BYTE_W-1:0];
                raw1 = cnt_lo < act[1][BYTE_W-1:0];
            end
            ST_SD_NRZ, ST_RZ_MARK: begin raw0 = sd_bit[0]; raw1 = sd_bit[1]; end
            ST_OFF, ST_RZ_SPACE: ;
        endcase
    end

    assign pwm_out0 = raw0 && !ctrl[7];
    assign pwm_out1 = raw1;

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt16 == '0 && acc[0] == '0 && acc[1] == '0));

    assert_var_in_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VAR) |-> (cnt16 <= act[0]));

    assert_var_out0_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VAR) |-> !pwm_out0);

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!pwm_out0 && !pwm_out1));

    assert_rz_space_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RZ_SPACE) |-> (!pwm_out0 && !pwm_out1));

endmodule

// File: tb/pwm_unit_test.sv
module pwm_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       div_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       pwm_out0, pwm_out1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_tick(div_tick), .ext_clk(ext_clk),
        .pwm_out0(pwm_out0), .pwm_out1(pwm_out1)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input int k);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s k=%0d actual=%0b expected=%0b", tag, k, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [15:0] v0, input logic [15:0] v1, input logic [7:0] c);
        wr(3'd0, 8'h00);
        wr(3'd1, v0[7:0]); wr(3'd2, v0[15:8]);
        wr(3'd3, v1[7:0]); wr(3'd4, v1[15:8]);
        wr(3'd0, c);
    endtask

    function automatic logic carry(input longint v, input longint n);
        if (n < 1) return 1'b0;
        return ((n * v) >> 16) != (((n - 1) * v) >> 16);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            chk(pwm_out0, 1'b0, "R1 out0", k);
            chk(pwm_out1, 1'b0, "R1 out1", k);
            @(negedge clk);
        end

        // R8: variable-period sweep, period 0..9, threshold 0..11
        for (int d1 = 0; d1 < 12; d1++) begin
            setup(16'd9, 16'(d1), 8'h13);
            for (int k = 0; k < 20; k++) begin
                chk(pwm_out1, (k % 10) < d1, "R8 out1", k);
                chk(pwm_out0, 1'b0, "R8 out0", k);
                @(negedge clk);
            end
        end

        // R6 R7: low byte alone ignored, high byte commits at wrap
        setup(16'd9, 16'd3, 8'h13);
        wr(3'd3, 8'd9);
        for (int k = 2; k < 22; k++) begin
            chk(pwm_out1, (k % 10) < 3, "R6 low byte alone", k);
            @(negedge clk);
        end
        wr(3'd4, 8'd0);
        for (int k = 24; k < 40; k++) begin
            chk(pwm_out1, (k < 30) ? ((k % 10) < 3) : ((k % 10) < 9), "R7 commit at wrap", k);
            @(negedge clk);
        end

        // R5: rewriting control restarts counter
        setup(16'd9, 16'd3, 8'h13);
        repeat (6) @(negedge clk);
        wr(3'd0, 8'h13);
        for (int k = 0; k < 10; k++) begin
            chk(pwm_out1, k < 3, "R5 restart", k);
            @(negedge clk);
        end

        // R4: prescale by 4 and by 16
        setup(16'd9, 16'd2, 8'h17);
        for (int k = 0; k < 60; k++) begin
            chk(pwm_out1, ((k / 4) % 10) < 2, "R4 div4", k);
            @(negedge clk);
        end
        setup(16'd9, 16'd1, 8'h1B);
        for (int k = 0; k < 200; k++) begin
            chk(pwm_out1, ((k / 16) % 10) < 1, "R4 div16", k);
            @(negedge clk);
        end

        // R3: divide-by-15 source with div_tick always set
        div_tick = 1'b1;
        setup(16'd100, 16'd2, 8'h10);
        for (int k = 0; k < 45; k++) begin
            chk(pwm_out1, k < 30, "R3 div15 source", k);
            @(negedge clk);
        end
        div_tick = 1'b0;

        // R3: external source, rising edge every 4 cycles
        setup(16'hFFFF, 16'd5, 8'h12);
        begin
            int high_len = 0;
            for (int k = 0; k < 40; k++) begin
                ext_clk = (k % 4) >= 2;
                if (pwm_out1) high_len++;
                @(negedge clk);
            end
            ext_clk = 1'b0;
            chk(high_len >= 16 && high_len <= 24, 1'b1, "R3 ext source rate", high_len);
        end

        // R9 R14: twin 16-bit, with and without output 0 gating
        setup(16'd5, 16'd3, 8'h33);
        for (int k = 0; k < 20; k++) begin
            chk(pwm_out0, k < 5, "R9 out0", k);
            chk(pwm_out1, k < 3, "R9 out1", k);
            @(negedge clk);
        end
        setup(16'd5, 16'd3, 8'hB3);
        for (int k = 0; k < 20; k++) begin
            chk(pwm_out0, 1'b0, "R14 gated out0", k);
            chk(pwm_out1, k < 3, "R14 out1 free", k);
            @(negedge clk);
        end

        // R10: twin 8-bit, separate periods, sweep duty of channel 0
        for (int lo = 0; lo < 6; lo++) begin
            setup({8'd4, 8'(lo)}, {8'd6, 8'd5}, 8'h23);
            for (int k = 0; k < 36; k++) begin
                chk(pwm_out0, (k % 5) < lo, "R10 out0", k);
                chk(pwm_out1, (k % 7) < 5, "R10 out1", k);
                @(negedge clk);
            end
        end

        // R11: dual 8-bit, period 256
        setup(16'h0080, 16'h0010, 8'h53);
        for (int k = 0; k < 520; k++) begin
            chk(pwm_out0, (k % 256) < 128, "R11 out0", k);
            chk(pwm_out1, (k % 256) < 16, "R11 out1", k);
            @(negedge clk);
        end

        // R12: NRZ sigma-delta
        setup(16'h4000, 16'hC000, 8'h43);
        for (int k = 0; k < 64; k++) begin
            chk(pwm_out0, carry(64'h4000, k), "R12 ch0", k);
            chk(pwm_out1, carry(64'hC000, k), "R12 ch1", k);
            @(negedge clk);
        end
        setup(16'h1235, 16'hFFFF, 8'h43);
        for (int k = 0; k < 64; k++) begin
            chk(pwm_out0, carry(64'h1235, k), "R12 ch0 b", k);
            chk(pwm_out1, carry(64'hFFFF, k), "R12 ch1 b", k);
            @(negedge clk);
        end

        // R13: RZ sigma-delta
        setup(16'h6000, 16'hE000, 8'h63);
        for (int k = 0; k < 64; k++) begin
            chk(pwm_out0, (k % 2 == 1) ? carry(64'h6000, (k + 1) / 2) : 1'b0, "R13 ch0", k);
            chk(pwm_out1, (k % 2 == 1) ? carry(64'hE000, (k + 1) / 2) : 1'b0, "R13 ch1", k);
            @(negedge clk);
        end

        // R2: reserved and disabled codes keep outputs low
        setup(16'h8000, 16'hFFFF, 8'h73);
        for (int k = 0; k < 20; k++) begin
            chk(pwm_out0 | pwm_out1, 1'b0, "R2 reserved", k);
            @(negedge clk);
        end
        setup(16'h8000, 16'hFFFF, 8'h03);
        for (int k = 0; k < 20; k++) begin
            chk(pwm_out0 | pwm_out1, 1'b0, "R2 disabled", k);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule